// File: doc/BRIEF.md
# Guard-Bit-Free Single-Precision Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words. Its arithmetic deliberately keeps no guard, round or sticky information. When the operand with the smaller exponent is aligned to the larger one, any significand bits that would fall off the right end are cleared before the add. The result is always truncated toward zero. A later left shift after cancellation can therefore never bring discarded bits back into the answer.

The unit also handles four other jobs:
- Non-finite inputs (exponent all ones) are clamped to the largest finite magnitude of the same sign.
- Inputs with a zero exponent are read as signed zeros.
- Results whose exponent would drop below one are flushed to a signed zero.
- Results that would overflow are clamped to the largest finite magnitude.

A caller presents both operands with a subtract select and a valid strobe. One clock later the registered result appears with its own valid strobe. The result register holds its value between strobes.

Top module: `guardless_fadd`

## Requirements
- R1: `outValid` is high in exactly the cycle after each cycle in which `inValid` is sampled high, and low otherwise. Reset clears `outValid` and `result` to zero.
- R2: In a cycle where `inValid` is low, `result` keeps its previous value.
- R3: Operands with equal exponents are combined without any masking (1.0 + 1.0 gives 0x40000000).
- R4: The sign bit is bit 31, the exponent is bits 30:23 and the stored mantissa is bits 22:0. When the exponents differ by d, with d from 1 to 23, the lowest d stored mantissa bits of the smaller-exponent operand are cleared before the add. Examples: 1.0 + 0x3F000001 gives 0x3FC00000, and 1.0 − 0x3F7FFFFF gives 0x34000000.
- R5: The masking applies to whichever operand has the smaller exponent, in either position. Swapping the operands of an add gives the same result.
- R6: When the exponent difference is 24 or more, the smaller operand becomes a zero with its own sign. Examples: 1.0 + 2^-24 and 1.0 − 2^-24 both give 0x3F800000.
- R7: Results are truncated toward zero, including the bit dropped when a carry-out renormalizes the sum. Example: 0x3F800003 + 0x3F800000 gives 0x40000001.
- R8: When `doSub` is 1, the sign of `opB` is inverted before the shared add path. Examples: 2.0 − 1.0 gives 0x3F800000, and 1.0 − 2.0 gives 0xBF800000.
- R9: An operand with exponent 255 is treated as exponent 254 with an all-ones mantissa, keeping its sign. No result ever has exponent 255.
- R10: A result that would need an exponent of 255 or more becomes 0x7F7FFFFF with the result's sign.
- R11: An operand with exponent 0 counts as zero of the same sign. A normalized result exponent below 1 becomes a zero carrying the result's sign. Every output with exponent 0 has a zero mantissa.
- R12: A zero-magnitude result is −0 only when both effective operand signs are negative; otherwise it is +0. Exact cancellation therefore gives +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and select are valid this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| doSub | input | 1 | 1 selects opA − opB, 0 selects opA + opB |
| outValid | output | 1 | Result valid, one cycle after inValid |
| result | output | 32 | Registered sum or difference |

## Verification
There is one register stage. An alignment, masking, sign or normalization fault therefore shows up in `result` on the very cycle `outValid` rises for the offending operands. The usual symptom is a low-order mantissa difference, or a wrong exponent after cancellation. A fault in the valid path or the hold enable shows within one cycle: `outValid` is wrong, or `result` changes on an idle cycle. The behavioural model in the bench predicts both outputs every clock. Hand-worked vectors cover the masking, truncation and zero-sign corners, where a guard-bit adder would differ.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRes;   // capture the computed word into the result register
  } ctrlStrobe_t;
endpackage

// File: rtl/fadd_lzc.sv
module fadd_lzc #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fadd_ctrl.sv
module fadd_ctrl import fadd_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.loadRes = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fadd_dpath.sv
module fadd_dpath import fadd_pkg::*; #(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              doSub,
  output logic [WORD_W-1:0] result
);
  localparam int SIG_W = MAN_W + 1;
  localparam int SUM_W = SIG_W + 1;
  localparam int LZ_W  = $clog2(SIG_W + 1);
  localparam int EXW   = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_TOP  = '1;
  localparam logic [EXP_W-1:0] EXP_MAXF = EXP_TOP - 1'b1;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
  } opnd_t;

  // clamp non-finite, squash zero-exponent mantissas, apply sign flip
  function automatic opnd_t cleanUp(input logic [WORD_W-1:0] w, input logic flip);
    opnd_t o;
    o.sgn = w[WORD_W-1] ^ flip;
    o.ex  = w[WORD_W-2:MAN_W];
    o.man = w[MAN_W-1:0];
    if (o.ex == EXP_TOP) begin
      o.ex  = EXP_MAXF;
      o.man = '1;
    end else if (o.ex == '0) begin
      o.man = '0;
    end
    return o;
  endfunction

  opnd_t             aC, bC, bigOp, smallOp;
  logic              aWins;
  logic [EXP_W-1:0]  expGap;
  logic [MAN_W-1:0]  keepMask;
  logic [SIG_W-1:0]  bigSig, smallSig;
  logic [SUM_W-1:0]  rawSum;
  logic [LZ_W-1:0]   lzCount;
  logic [SIG_W-1:0]  normSig;
  logic [EXW-1:0]    expAdj;
  logic [EXP_W:0]    expUp;
  logic [WORD_W-1:0] nextRes;

  // ordering and alignment
  always_comb begin
    aC    = cleanUp(opA, 1'b0);
    bC    = cleanUp(opB, doSub);
    aWins = (aC.ex > bC.ex) || ((aC.ex == bC.ex) && (aC.man >= bC.man));
    bigOp   = aWins ? aC : bC;
    smallOp = aWins ? bC : aC;
    expGap   = bigOp.ex - smallOp.ex;
    keepMask = {MAN_W{1'b1}} << expGap;
    bigSig   = {bigOp.ex != '0, bigOp.man};
    if (expGap >= EXP_W'(SIG_W)) smallSig = '0;
    else smallSig = {smallOp.ex != '0, smallOp.man & keepMask} >> expGap;
    if (bigOp.sgn == smallOp.sgn) rawSum = {1'b0, bigSig} + {1'b0, smallSig};
    else                          rawSum = {1'b0, bigSig} - {1'b0, smallSig};
  end

  fadd_lzc #(.W(SIG_W)) uLzc (
    .vec  (rawSum[SIG_W-1:0]),
    .zeros(lzCount)
  );

  // normalization, clamping and flushing
  always_comb begin
    normSig = rawSum[SIG_W-1:0] << lzCount;
    expAdj  = {2'b00, bigOp.ex} - EXW'(lzCount);
    expUp   = {1'b0, bigOp.ex} + 1'b1;
    if (rawSum == '0) begin
      nextRes = {aC.sgn & bC.sgn, {(WORD_W-1){1'b0}}};
    end else if (rawSum[SIG_W]) begin
      if (expUp >= {1'b0, EXP_TOP}) nextRes = {bigOp.sgn, EXP_MAXF, {MAN_W{1'b1}}};
      else nextRes = {bigOp.sgn, expUp[EXP_W-1:0], rawSum[SIG_W-1:1]};
    end else if (expAdj[EXW-1] || (expAdj == '0)) begin
      nextRes = {bigOp.sgn, {(WORD_W-1){1'b0}}};
    end else begin
      nextRes = {bigOp.sgn, expAdj[EXP_W-1:0], normSig[MAN_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               result <= '0;
    else if (strobe.loadRes) result <= nextRes;
  end
endmodule

// File: rtl/guardless_fadd.sv
module guardless_fadd import fadd_pkg::*; #(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              doSub,
  output logic              outValid,
  output logic [WORD_W-1:0] result
);
  ctrlStrobe_t strobe;

  fadd_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  fadd_dpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uDpath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .doSub (doSub),
    .result(result)
  );
endmodule

// File: rtl/fadd_checker.sv
module fadd_checker #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [WORD_W-1:0] result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                          // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                        // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));                                  // R2
  AST_NO_TOP_EXPONENT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (result[WORD_W-2:MAN_W] != '1));                   // R9
  AST_ZERO_EXP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (result[WORD_W-2:MAN_W] == '0)) |-> (result[MAN_W-1:0] == '0)); // R11
endmodule

bind guardless_fadd fadd_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .result  (result)
);

// File: tb/tb_guardless_fadd.sv
module tb_guardless_fadd;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        doSub = 1'b0;
  logic        outValid;
  logic [31:0] result;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;
  logic        expV = 1'b0;
  logic [31:0] expR = '0;
  string curTag = "R3";
  string resTag = "R1";

  always #4ns clk = ~clk;   // 125 MHz

  guardless_fadd dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .doSub(doSub), .outValid(outValid), .result(result)
  );

  // behavioural reference: integer significands, plain right shift for alignment
  function automatic logic [31:0] refAdd(logic [31:0] a, logic [31:0] b, logic sub);
    int ea = int'(a[30:23]);
    int eb = int'(b[30:23]);
    bit sa = a[31];
    bit sb = b[31] ^ sub;
    longint ma, mb, s, m;
    int e;
    bit rs;
    if (ea == 255) begin ea = 254; ma = 64'hFFFFFF; end
    else ma = (ea == 0) ? 0 : longint'({1'b1, a[22:0]});
    if (eb == 255) begin eb = 254; mb = 64'hFFFFFF; end
    else mb = (eb == 0) ? 0 : longint'({1'b1, b[22:0]});
    e = (ea > eb) ? ea : eb;
    if (ea < e) ma = ((e - ea) >= 24) ? 0 : (ma >> (e - ea));
    if (eb < e) mb = ((e - eb) >= 24) ? 0 : (mb >> (e - eb));
    s = (sa ? -ma : ma) + (sb ? -mb : mb);
    if (s == 0) return {sa & sb, 31'b0};
    rs = (s < 0);
    m = rs ? -s : s;
    while (m >= 64'h1000000) begin m = m >> 1; e++; end
    while (m < 64'h800000) begin m = m << 1; e--; end
    if (e >= 255) return {rs, 8'hFE, 23'h7FFFFF};
    if (e < 1) return {rs, 31'b0};
    return {rs, e[7:0], m[22:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: model updates at the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      expV = 1'b0; expR = '0; resTag = "R1";
    end else begin
      if (inValid) begin expR = refAdd(opA, opB, doSub); resTag = curTag; end
      else resTag = "R2";
      expV = inValid;
    end
    @(negedge clk);
    chk("R1", {31'b0, outValid}, {31'b0, expV});
    chk(resTag, result, expR);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic sub,
                      input string tag, input logic [31:0] want);
    opA = a; opB = b; doSub = sub; inValid = 1'b1; curTag = tag;
    tick();
    inValid = 1'b0;
    chk(tag, result, want);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      nChecks++; nBad++;
      $display("FAIL R1 watchdog expired");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset valid", {31'b0, outValid}, 32'd0);
    chk("R1 reset result", result, 32'd0);
    rstN = 1'b1;
    tick();

    send(32'h3F800000, 32'h3F800000, 1'b0, "R3", 32'h40000000);
    send(32'h3F800000, 32'h3F000001, 1'b0, "R4", 32'h3FC00000);
    send(32'h3F000001, 32'h3F800000, 1'b0, "R5", 32'h3FC00000);
    send(32'h3F800000, 32'h3F7FFFFF, 1'b1, "R4", 32'h34000000);
    send(32'h3F7FFFFF, 32'h3F800000, 1'b1, "R5", 32'hB4000000);
    send(32'h3F800000, 32'h33800000, 1'b0, "R6", 32'h3F800000);
    send(32'h3F800000, 32'h33800000, 1'b1, "R6", 32'h3F800000);
    send(32'h3F800003, 32'h3F800000, 1'b0, "R7", 32'h40000001);
    send(32'h40000000, 32'h3F800000, 1'b1, "R8", 32'h3F800000);
    send(32'h3F800000, 32'h40000000, 1'b1, "R8", 32'hBF800000);
    send(32'h7F800000, 32'h00000000, 1'b0, "R9", 32'h7F7FFFFF);
    send(32'hFFC00000, 32'h00000000, 1'b0, "R9", 32'hFF7FFFFF);
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R10", 32'h7F7FFFFF);
    send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R10", 32'hFF7FFFFF);
    send(32'h00000001, 32'h3F800000, 1'b0, "R11", 32'h3F800000);
    send(32'h80800001, 32'h80800000, 1'b1, "R11", 32'h80000000);
    send(32'h3F800000, 32'h3F800000, 1'b1, "R12", 32'h00000000);
    send(32'h80000000, 32'h80000000, 1'b0, "R12", 32'h80000000);
    send(32'h80000000, 32'h00000000, 1'b1, "R12", 32'h80000000);
    send(32'h00000000, 32'h80000000, 1'b0, "R12", 32'h00000000);
    repeat (3) tick();   // idle: result must hold (R2)

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      int eb;
      a = $urandom;
      b = $urandom;
      if (($urandom % 3) != 0) begin
        eb = int'(a[30:23]) + int'($urandom % 53) - 26;
        if (eb < 0) eb = 0;
        if (eb > 255) eb = 255;
        b[30:23] = eb[7:0];
      end
      opA = a; opB = b; doSub = $urandom % 2;
      inValid = ($urandom % 4) != 0;
      curTag = (a[30:23] == b[30:23]) ? "R3" : "R4";
      tick();
    end
    inValid = 1'b0;
    tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule